// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Stage

This block turns a serial word stream into a parallel 14-bit converter code, using two registers in a row. A host holds an active-low frame line low, then presents one bit per falling edge of a transmit clock, most significant bit first. When the last bit of a word has been captured, the assembled word moves into a staging register. A separate active-low load strobe moves the staged word into the code register that drives the converter. Because the load strobe is separate from the serial stream, several converters can be loaded over time and then updated at one chosen instant.

All serial and strobe inputs are asynchronous to the system clock. The block passes each one through a synchronizer of equal depth and detects edges in the system clock domain. A word is committed only when all of its bits arrive inside one frame. A frame that closes early leaves the staging register untouched. Codes are offset binary: 0x0000 is the most negative output, 0x3FFF the most positive and 0x2000 is zero volts.

Top module: `dac_serial_stage`

## Requirements
- R1: A synchronous reset sets both `staged_code` and `dac_code` to mid-scale, 0x2000 in offset binary.
- R2: While `tframe_n` is low, each falling edge of `tclk` captures `tdata`, first bit as the MSB. The 14th captured bit writes the full word to `staged_code`.
- R3: Falling edges of `tclk` while `tframe_n` is high capture nothing: `staged_code` and `dac_code` stay unchanged.
- R4: If `tframe_n` rises before 14 bits have been captured, the partial word is discarded and `staged_code` keeps its previous value.
- R5: Bits clocked after the 14th in the same frame are ignored: `staged_code` keeps the first complete word.
- R6: `dac_code` changes only on a falling edge of `load_n`. A newly staged word, a rising edge of `load_n` or a held level leaves it unchanged.
- R7: A falling edge of `load_n` copies `staged_code` into `dac_code`.
- R8: If the falling edge of `load_n` and the 14th bit's falling `tclk` edge are detected in the same system clock cycle, `dac_code` receives the newly completed word, not the previously staged one.
- R9: After a discarded partial frame, the next frame counts its bits from zero and commits a full word normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk | input | 1 | Asynchronous serial transmit clock; bits are taken on its falling edge |
| tframe_n | input | 1 | Asynchronous active-low word frame |
| tdata | input | 1 | Asynchronous serial data, MSB first |
| load_n | input | 1 | Asynchronous active-low load strobe; its falling edge updates the converter code |
| staged_code | output | 14 | Staging register (first stage) |
| dac_code | output | 14 | Converter code register (second stage), offset binary |

## Verification
Two events can fall in the same system cycle: a word commit from the serial path and a load request from the strobe path. The bench provokes this by driving the 14th falling `tclk` edge and the falling `load_n` edge at the same instant. The synchronizers have equal depth, so both edges are detected on the same clock. The check passes only if `dac_code` then shows the word just completed and not the word staged before it.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;

    localparam int CODE_W_DEF     = 14;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_e;

    function automatic edge_e classify_edge(input logic prev_lvl, input logic cur_lvl);
        if (prev_lvl && !cur_lvl)      return EDGE_FALL;
        else if (!prev_lvl && cur_lvl) return EDGE_RISE;
        else                           return EDGE_NONE;
    endfunction

    function automatic int count_width(input int bits);
        return $clog2(bits + 1);
    endfunction

endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
    parameter int   DEPTH   = 2,
    parameter logic IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {DEPTH{IDLE_LV}};
        else     chain <= {chain[DEPTH-2:0], async_in};
    end

    assign sync_out = chain[DEPTH-1];
endmodule

// File: rtl/dsl_shift_capture.sv
module dsl_shift_capture
    import dac_stage_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_hi,
    input  logic              bit_strobe,
    input  logic              bit_val,
    output logic              commit,
    output logic [CODE_W-1:0] commit_word
);
    localparam int CNT_W = count_width(CODE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);

    logic [CODE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              take;

    assign take        = bit_strobe && !frame_hi && (cnt != FULL);
    assign commit      = take && (cnt == LAST);
    assign commit_word = {shreg[CODE_W-2:0], bit_val};

    always_ff @(posedge clk) begin
        if (rst || frame_hi) begin
            cnt <= '0;
        end else if (take) begin
            shreg <= commit_word;
            cnt   <= cnt + 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= FULL); // R5
    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (rst) frame_hi |=> cnt == '0); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && !frame_hi) |=> (cnt == FULL || $past(frame_hi))); // R5
endmodule

// File: rtl/dsl_latch_pair.sv
module dsl_latch_pair
    import dac_stage_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [CODE_W-1:0] commit_word,
    input  logic              load_lvl,
    output logic [CODE_W-1:0] staged_q,
    output logic [CODE_W-1:0] dac_q
);
    localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

    logic  load_prev;
    edge_e load_edge;
    logic  load_fire;

    assign load_edge = classify_edge(load_prev, load_lvl);
    assign load_fire = (load_edge == EDGE_FALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_prev <= 1'b1;
            staged_q  <= MIDSCALE;
            dac_q     <= MIDSCALE;
        end else begin
            load_prev <= load_lvl;
            if (commit) staged_q <= commit_word;
            if (load_fire) dac_q <= commit ? commit_word : staged_q;
        end
    end

    AST_RESET_MID: assert property (@(posedge clk) rst |=> (staged_q == MIDSCALE && dac_q == MIDSCALE)); // R1
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst) !load_fire |=> $stable(dac_q)); // R6
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst) !commit |=> $stable(staged_q)); // R4
    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (rst) load_fire |=> dac_q == staged_q); // R8
endmodule

// File: rtl/dac_serial_stage.sv
module dac_serial_stage
    import dac_stage_pkg::*;
#(
    parameter int CODE_W     = CODE_W_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tclk,
    input  logic              tframe_n,
    input  logic              tdata,
    input  logic              load_n,
    output logic [CODE_W-1:0] staged_code,
    output logic [CODE_W-1:0] dac_code
);
    logic tclk_s, frame_s, data_s, load_s;
    logic tclk_prev;
    logic bit_strobe;
    logic commit;
    logic [CODE_W-1:0] commit_word;

    dsl_sync #(.DEPTH(SYNC_DEPTH), .IDLE_LV(1'b1)) u_sync_clk (
        .clk(clk), .rst(rst), .async_in(tclk), .sync_out(tclk_s));
    dsl_sync #(.DEPTH(SYNC_DEPTH), .IDLE_LV(1'b1)) u_sync_frame (
        .clk(clk), .rst(rst), .async_in(tframe_n), .sync_out(frame_s));
    dsl_sync #(.DEPTH(SYNC_DEPTH), .IDLE_LV(1'b0)) u_sync_data (
        .clk(clk), .rst(rst), .async_in(tdata), .sync_out(data_s));
    dsl_sync #(.DEPTH(SYNC_DEPTH), .IDLE_LV(1'b1)) u_sync_load (
        .clk(clk), .rst(rst), .async_in(load_n), .sync_out(load_s));

    always_ff @(posedge clk) begin
        if (rst) tclk_prev <= 1'b1;
        else     tclk_prev <= tclk_s;
    end

    assign bit_strobe = (classify_edge(tclk_prev, tclk_s) == EDGE_FALL);

    dsl_shift_capture #(.CODE_W(CODE_W)) u_capture (
        .clk(clk), .rst(rst), .frame_hi(frame_s), .bit_strobe(bit_strobe),
        .bit_val(data_s), .commit(commit), .commit_word(commit_word));

    dsl_latch_pair #(.CODE_W(CODE_W)) u_latches (
        .clk(clk), .rst(rst), .commit(commit), .commit_word(commit_word),
        .load_lvl(load_s), .staged_q(staged_code), .dac_q(dac_code));

    AST_COMMIT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        commit |-> !frame_s); // R3
endmodule

// File: tb/dac_serial_stage_bench.sv
module dac_serial_stage_bench;
    localparam int W = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tclk = 1'b1, tframe_n = 1'b1, tdata = 1'b0, load_n = 1'b1;
    logic [W-1:0] staged_code, dac_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [W-1:0] VEC [6] = '{14'h0000, 14'h3FFF, 14'h2AAA,
                                         14'h1555, 14'h2001, 14'h1FFF};

    always #2.5 clk = ~clk;

    dac_serial_stage u_dac_serial_stage (
        .clk(clk), .rst(rst), .tclk(tclk), .tframe_n(tframe_n), .tdata(tdata),
        .load_n(load_n), .staged_code(staged_code), .dac_code(dac_code));

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b);
        tdata = b;
        wait_cyc(10);
        tclk = 1'b0;
        wait_cyc(10);
        tclk = 1'b1;
    endtask

    // sends the top nbits of word, MSB first, inside one frame
    task automatic send_bits(input logic [W-1:0] word, input int nbits);
        tframe_n = 1'b0;
        wait_cyc(10);
        for (int i = 0; i < nbits; i++) clock_bit(word[W-1-i]);
        wait_cyc(10);
        tframe_n = 1'b1;
        wait_cyc(10);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_cyc(10);
        load_n = 1'b1;
        wait_cyc(10);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 14'h0, 14'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev_dac;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(4);
        check("R1 staged reset", staged_code, 14'h2000);
        check("R1 dac reset", dac_code, 14'h2000);

        // table walk: stage each word, confirm dac holds, then load
        prev_dac = 14'h2000;
        for (int k = 0; k < 6; k++) begin
            send_bits(VEC[k], W);
            check("R2 staged word", staged_code, VEC[k]);
            check("R6 dac holds before load", dac_code, prev_dac);
            pulse_load();
            check("R7 dac after load", dac_code, VEC[k]);
            prev_dac = VEC[k];
        end

        // R3: clock edges with frame high
        for (int i = 0; i < W + 2; i++) clock_bit(1'b0);
        wait_cyc(10);
        check("R3 staged unchanged", staged_code, 14'h1FFF);
        check("R3 dac unchanged", dac_code, 14'h1FFF);

        // R4: partial word then frame closes
        send_bits(14'h0F0F, 9);
        check("R4 partial discarded", staged_code, 14'h1FFF);

        // R9: fresh frame after discard
        send_bits(14'h3C3A, W);
        check("R9 fresh count", staged_code, 14'h3C3A);

        // R5: extra bits beyond 14 in one frame
        tframe_n = 1'b0;
        wait_cyc(10);
        for (int i = 0; i < W; i++) clock_bit(14'h0123 >> (W-1-i));
        for (int i = 0; i < 5; i++) clock_bit(1'b1);
        wait_cyc(10);
        tframe_n = 1'b1;
        wait_cyc(10);
        check("R5 extra bits ignored", staged_code, 14'h0123);

        // R6: load rising edge / held low do not update
        load_n = 1'b0;
        wait_cyc(10);
        check("R7 load fall", dac_code, 14'h0123);
        send_bits(14'h2468, W);
        check("R6 held low no update", dac_code, 14'h0123);
        load_n = 1'b1;
        wait_cyc(10);
        check("R6 rising no update", dac_code, 14'h0123);

        // R8: commit and load fall in the same cycle
        tframe_n = 1'b0;
        wait_cyc(10);
        for (int i = 0; i < W-1; i++) clock_bit(14'h1ABC >> (W-1-i));
        tdata = 1'b0;
        wait_cyc(10);
        tclk = 1'b0;
        load_n = 1'b0;
        wait_cyc(10);
        check("R8 same cycle dac", dac_code, 14'h1ABC);
        check("R8 same cycle staged", staged_code, 14'h1ABC);
        tclk = 1'b1;
        load_n = 1'b1;
        tframe_n = 1'b1;
        wait_cyc(10);

        // R1: reset mid-run
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(2);
        check("R1 reset again dac", dac_code, 14'h2000);
        check("R1 reset again staged", staged_code, 14'h2000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule